// File: doc/BRIEF.md
# UART Automatic Flow Control Unit

This unit sits beside one UART channel and paces traffic in both directions without help from software. It watches the fill level of the local receive FIFO and drives the request-to-send output from it. A clear-to-send input, synchronised on entry, pauses the start of new characters. It can insert pause and resume characters into the transmit stream, and it can recognise such characters on the receive side. A matching pause from the far end holds back transmit data until a resume arrives. A programmable special character is flagged when it is received, but it still passes into the receive stream.

The unit sits between the receive deserialiser and the receive FIFO, and between the transmit FIFO and the transmit shifter. On the receive side it takes each character as a one-cycle strobe and hands the data characters on as a registered strobe. On the transmit side it pulls a byte from the FIFO head with a pop pulse, and gives the shifter a one-cycle load pulse and a data byte. The shifter reports `shifter_busy` from the cycle after a load until the frame has gone out. Received characters are spaced at least three clock cycles apart, which a serial line always satisfies.

Top module: `auto_flow_ctrl`

## Requirements
- R1: Configuration writes (`cfg_we` high) go to the register at `cfg_addr`: 0 feature, 1 trigger select, 2 resume-1, 3 resume-2, 4 pause-1, 5 pause-2, 6 special. The feature bits are: bit0 transmit insertion, bit1 receive recognition, bit2 two-character mode, bit3 special detect, bit4 automatic RTS, bit5 automatic CTS. The trigger select picks a level of DEPTH/4, DEPTH/2, 3*DEPTH/4 or DEPTH-4 (8, 16, 24 or 28 at the default depth). Reset values: resume-1 = 0x11, pause-1 = 0x13, everything else 0.
- R2: With automatic RTS on, `rts_n` goes to 1 in the cycle after the receive level is at or above the trigger, goes to 0 after the level drops below trigger-1, and holds in between. With automatic RTS off, `rts_n` is 1.
- R3: With automatic CTS on, no character (data or control) is loaded while the synchronised `cts_n` is 1. The synchroniser is two flops.
- R4: When the unit is free to send, the FIFO head byte is loaded into the shifter together with a pop pulse. There is never a load while `shifter_busy` is high, and never two loads in consecutive cycles. Bytes keep their order.
- R5: With transmit insertion on, pause-1 is sent once when the receive level is at or above the trigger. Resume-1 is sent once when the level later falls below the trigger. In two-character mode, pause-2 or resume-2 follows directly after.
- R6: A pending inserted character goes ahead of any waiting FIFO byte but never cuts into the character already shifting. Inserted characters ignore a remote pause.
- R7: With receive recognition on in single mode, a received pause-1 stops data loads, and a received resume-1 lets them go again. Neither character is passed to the receive stream.
- R8: In two-character mode, only pause-1 followed by pause-2 (or resume-1 followed by resume-2) acts, and the pair is removed. If the first character is followed by anything else, the first character is released to the stream, and then the second is processed normally, in order.
- R9: With special detect on, a character equal to the special register is passed to the stream, and `special_det` pulses in the same cycle as its store strobe.
- R10: After reset, `rts_n` is 1 and `shifter_load`, `tx_fifo_pop`, `rx_store_valid` and `special_det` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register index |
| cfg_wdata | input | 8 | Configuration write data |
| rx_level | input | LVL_W | Receive FIFO occupancy |
| rx_valid | input | 1 | Received character strobe |
| rx_char | input | 8 | Received character |
| rx_store_valid | output | 1 | Write strobe into the receive FIFO |
| rx_store_data | output | 8 | Character written into the receive FIFO |
| special_det | output | 1 | Special character seen, with its store strobe |
| tx_fifo_valid | input | 1 | Transmit FIFO not empty |
| tx_fifo_data | input | 8 | Transmit FIFO head byte |
| tx_fifo_pop | output | 1 | Remove the transmit FIFO head |
| shifter_busy | input | 1 | Transmit shifter sending a frame |
| shifter_load | output | 1 | Start a frame with `shifter_data` |
| shifter_data | output | 8 | Character to send |
| cts_n | input | 1 | Remote clear to send, active low, asynchronous |
| rts_n | output | 1 | Local request to send, active low |

## Verification
On every cycle the assertions check the transmit-side rules: no load while the shifter is busy, no back-to-back loads, and no load after a synchronised CTS that was inactive. They also check that the RTS output follows the hysteresis bands, that a special flag never appears without a store, and that a single-mode pause character never reaches the receive stream. Some behaviours depend on order over many cycles, so only the bench scenarios can show them. These are the exact byte order on the line when an inserted pause overtakes waiting data, the one-shot nature of pause and resume insertion, the halt and resume of data by received characters, and the release of a partial two-character match before the character that broke it.

// File: rtl/fc_pkg.sv
package fc_pkg;
  localparam int CHAR_W = 8;

  localparam logic [2:0] ADDR_FEAT = 3'd0;
  localparam logic [2:0] ADDR_TRIG = 3'd1;
  localparam logic [2:0] ADDR_ON1  = 3'd2;
  localparam logic [2:0] ADDR_ON2  = 3'd3;
  localparam logic [2:0] ADDR_OFF1 = 3'd4;
  localparam logic [2:0] ADDR_OFF2 = 3'd5;
  localparam logic [2:0] ADDR_SPEC = 3'd6;

  localparam logic [7:0] ON1_RST  = 8'h11;
  localparam logic [7:0] OFF1_RST = 8'h13;

  typedef struct packed {
    logic cts_en;
    logic rts_en;
    logic spec_en;
    logic dual;
    logic rx_sw;
    logic tx_sw;
  } feat_t;

  typedef enum logic [1:0] {
    CTL_IDLE   = 2'd0,
    CTL_FIRST  = 2'd1,
    CTL_SECOND = 2'd2
  } ctl_state_e;
endpackage

// File: rtl/fc_cfg_regs.sv
module fc_cfg_regs
  import fc_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output feat_t             feat,
  output logic [LVL_W-1:0]  trig_level,
  output logic [7:0]        on1,
  output logic [7:0]        on2,
  output logic [7:0]        off1,
  output logic [7:0]        off2,
  output logic [7:0]        spec
);
  localparam logic [LVL_W-1:0] TRIG0 = LVL_W'(DEPTH / 4);
  localparam logic [LVL_W-1:0] TRIG1 = LVL_W'(DEPTH / 2);
  localparam logic [LVL_W-1:0] TRIG2 = LVL_W'((3 * DEPTH) / 4);
  localparam logic [LVL_W-1:0] TRIG3 = LVL_W'(DEPTH - 4);

  logic [5:0] feat_q, feat_d;
  logic [1:0] sel_q, sel_d;
  logic [7:0] on1_d, on2_d, off1_d, off2_d, spec_d;

  always_comb begin
    feat_d = feat_q;
    sel_d  = sel_q;
    on1_d  = on1;
    on2_d  = on2;
    off1_d = off1;
    off2_d = off2;
    spec_d = spec;
    if (cfg_we) begin
      case (cfg_addr)
        ADDR_FEAT: feat_d = cfg_wdata[5:0];
        ADDR_TRIG: sel_d  = cfg_wdata[1:0];
        ADDR_ON1:  on1_d  = cfg_wdata;
        ADDR_ON2:  on2_d  = cfg_wdata;
        ADDR_OFF1: off1_d = cfg_wdata;
        ADDR_OFF2: off2_d = cfg_wdata;
        ADDR_SPEC: spec_d = cfg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      feat_q <= '0;
      sel_q  <= '0;
      on1    <= ON1_RST;
      on2    <= '0;
      off1   <= OFF1_RST;
      off2   <= '0;
      spec   <= '0;
    end else begin
      feat_q <= feat_d;
      sel_q  <= sel_d;
      on1    <= on1_d;
      on2    <= on2_d;
      off1   <= off1_d;
      off2   <= off2_d;
      spec   <= spec_d;
    end
  end

  assign feat.tx_sw   = feat_q[0];
  assign feat.rx_sw   = feat_q[1];
  assign feat.dual    = feat_q[2];
  assign feat.spec_en = feat_q[3];
  assign feat.rts_en  = feat_q[4];
  assign feat.cts_en  = feat_q[5];

  always_comb begin
    case (sel_q)
      2'd0:    trig_level = TRIG0;
      2'd1:    trig_level = TRIG1;
      2'd2:    trig_level = TRIG2;
      default: trig_level = TRIG3;
    endcase
  end
endmodule

// File: rtl/fc_sync.sv
module fc_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RESET_VAL}};
    end else begin
      chain_q[0] <= din;
      for (int i = 1; i < STAGES; i++) begin
        chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/fc_rts_ctrl.sv
module fc_rts_ctrl #(
  parameter int LVL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rts_en,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] trig_level,
  output logic             rts_n
);
  logic rts_d;
  logic [LVL_W-1:0] low_mark;

  assign low_mark = trig_level - LVL_W'(1);

  always_comb begin
    rts_d = rts_n;
    if (!rts_en) begin
      rts_d = 1'b1;
    end else if (level >= trig_level) begin
      rts_d = 1'b1;
    end else if (level < low_mark) begin
      rts_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rts_n <= 1'b1;
    else        rts_n <= rts_d;
  end
endmodule

// File: rtl/fc_rx_filter.sv
module fc_rx_filter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_sw,
  input  logic       dual,
  input  logic       spec_en,
  input  logic [7:0] on1,
  input  logic [7:0] on2,
  input  logic [7:0] off1,
  input  logic [7:0] off2,
  input  logic [7:0] spec,
  input  logic       rx_valid,
  input  logic [7:0] rx_char,
  output logic       store_valid,
  output logic [7:0] store_data,
  output logic       special_det,
  output logic       remote_halt
);
  logic       hold_v, hold_v_d;
  logic       hold_off, hold_off_d;
  logic [7:0] hold_c, hold_c_d;
  logic       rep_v, rep_v_d;
  logic [7:0] rep_c, rep_c_d;
  logic       halt_d;
  logic       st_v_d, sp_d;
  logic [7:0] st_c_d;
  logic       in_v;
  logic [7:0] in_c;

  assign in_v = rep_v | rx_valid;
  assign in_c = rep_v ? rep_c : rx_char;

  always_comb begin
    hold_v_d   = hold_v;
    hold_off_d = hold_off;
    hold_c_d   = hold_c;
    rep_v_d    = 1'b0;
    rep_c_d    = rep_c;
    halt_d     = remote_halt;
    st_v_d     = 1'b0;
    st_c_d     = store_data;

    if (hold_v && (!rx_sw || !dual)) begin
      st_v_d   = 1'b1;
      st_c_d   = hold_c;
      hold_v_d = 1'b0;
      rep_v_d  = in_v;
      rep_c_d  = in_c;
    end else if (in_v) begin
      if (!rx_sw) begin
        st_v_d = 1'b1;
        st_c_d = in_c;
      end else if (hold_v) begin
        hold_v_d = 1'b0;
        if (in_c == (hold_off ? off2 : on2)) begin
          halt_d = hold_off;
        end else begin
          st_v_d  = 1'b1;
          st_c_d  = hold_c;
          rep_v_d = 1'b1;
          rep_c_d = in_c;
        end
      end else if (in_c == off1) begin
        if (dual) begin
          hold_v_d   = 1'b1;
          hold_off_d = 1'b1;
          hold_c_d   = in_c;
        end else begin
          halt_d = 1'b1;
        end
      end else if (in_c == on1) begin
        if (dual) begin
          hold_v_d   = 1'b1;
          hold_off_d = 1'b0;
          hold_c_d   = in_c;
        end else begin
          halt_d = 1'b0;
        end
      end else begin
        st_v_d = 1'b1;
        st_c_d = in_c;
      end
    end

    if (!rx_sw) halt_d = 1'b0;
    sp_d = st_v_d && spec_en && (st_c_d == spec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v      <= 1'b0;
      hold_off    <= 1'b0;
      hold_c      <= '0;
      rep_v       <= 1'b0;
      rep_c       <= '0;
      remote_halt <= 1'b0;
      store_valid <= 1'b0;
      store_data  <= '0;
      special_det <= 1'b0;
    end else begin
      hold_v      <= hold_v_d;
      hold_off    <= hold_off_d;
      hold_c      <= hold_c_d;
      rep_v       <= rep_v_d;
      rep_c       <= rep_c_d;
      remote_halt <= halt_d;
      store_valid <= st_v_d;
      store_data  <= st_c_d;
      special_det <= sp_d;
    end
  end
endmodule

// File: rtl/fc_tx_arb.sv
module fc_tx_arb
  import fc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_sw,
  input  logic       dual,
  input  logic [7:0] on1,
  input  logic [7:0] on2,
  input  logic [7:0] off1,
  input  logic [7:0] off2,
  input  logic       above,
  input  logic       below,
  input  logic       cts_ok,
  input  logic       remote_halt,
  input  logic       shifter_busy,
  input  logic       fifo_valid,
  input  logic [7:0] fifo_data,
  output logic       load,
  output logic [7:0] data,
  output logic       pop
);
  ctl_state_e st_q, st_d;
  logic       off_q, off_d;
  logic       sent_q, sent_d;
  logic       load_d, pop_d;
  logic [7:0] data_d;
  logic       can_start, data_ok;

  assign can_start = !shifter_busy && !load && cts_ok;
  assign data_ok   = can_start && !remote_halt && fifo_valid;

  always_comb begin
    st_d   = st_q;
    off_d  = off_q;
    sent_d = sent_q;
    load_d = 1'b0;
    pop_d  = 1'b0;
    data_d = data;
    if (!tx_sw) begin
      st_d   = CTL_IDLE;
      sent_d = 1'b0;
      if (data_ok) begin
        load_d = 1'b1;
        pop_d  = 1'b1;
        data_d = fifo_data;
      end
    end else begin
      case (st_q)
        CTL_IDLE: begin
          if (!sent_q && above) begin
            st_d  = CTL_FIRST;
            off_d = 1'b1;
          end else if (sent_q && below) begin
            st_d  = CTL_FIRST;
            off_d = 1'b0;
          end else if (data_ok) begin
            load_d = 1'b1;
            pop_d  = 1'b1;
            data_d = fifo_data;
          end
        end
        CTL_FIRST: begin
          if (can_start) begin
            load_d = 1'b1;
            data_d = off_q ? off1 : on1;
            if (dual) begin
              st_d = CTL_SECOND;
            end else begin
              st_d   = CTL_IDLE;
              sent_d = off_q;
            end
          end
        end
        default: begin
          if (can_start) begin
            load_d = 1'b1;
            data_d = off_q ? off2 : on2;
            st_d   = CTL_IDLE;
            sent_d = off_q;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CTL_IDLE;
      off_q  <= 1'b0;
      sent_q <= 1'b0;
      load   <= 1'b0;
      pop    <= 1'b0;
      data   <= '0;
    end else begin
      st_q   <= st_d;
      off_q  <= off_d;
      sent_q <= sent_d;
      load   <= load_d;
      pop    <= pop_d;
      data   <= data_d;
    end
  end
endmodule

// File: rtl/auto_flow_ctrl.sv
module auto_flow_ctrl
  import fc_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int SYNC_STAGES = 2,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [7:0]       cfg_wdata,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_valid,
  input  logic [7:0]       rx_char,
  output logic             rx_store_valid,
  output logic [7:0]       rx_store_data,
  output logic             special_det,
  input  logic             tx_fifo_valid,
  input  logic [7:0]       tx_fifo_data,
  output logic             tx_fifo_pop,
  input  logic             shifter_busy,
  output logic             shifter_load,
  output logic [7:0]       shifter_data,
  input  logic             cts_n,
  output logic             rts_n
);
  feat_t            feat;
  logic [LVL_W-1:0] trig_level;
  logic [7:0]       on1, on2, off1, off2, spec;
  logic             cts_s;
  logic             remote_halt;
  logic             above, below;

  fc_cfg_regs #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .feat(feat), .trig_level(trig_level),
    .on1(on1), .on2(on2), .off1(off1), .off2(off2), .spec(spec)
  );

  fc_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_cts_sync (
    .clk(clk), .rst_n(rst_n), .din(cts_n), .dout(cts_s)
  );

  fc_rts_ctrl #(.LVL_W(LVL_W)) u_rts (
    .clk(clk), .rst_n(rst_n), .rts_en(feat.rts_en), .level(rx_level),
    .trig_level(trig_level), .rts_n(rts_n)
  );

  fc_rx_filter u_rx (
    .clk(clk), .rst_n(rst_n), .rx_sw(feat.rx_sw), .dual(feat.dual),
    .spec_en(feat.spec_en), .on1(on1), .on2(on2), .off1(off1), .off2(off2),
    .spec(spec), .rx_valid(rx_valid), .rx_char(rx_char),
    .store_valid(rx_store_valid), .store_data(rx_store_data),
    .special_det(special_det), .remote_halt(remote_halt)
  );

  assign above = rx_level >= trig_level;
  assign below = rx_level < trig_level;

  fc_tx_arb u_tx (
    .clk(clk), .rst_n(rst_n), .tx_sw(feat.tx_sw), .dual(feat.dual),
    .on1(on1), .on2(on2), .off1(off1), .off2(off2),
    .above(above), .below(below), .cts_ok(!feat.cts_en || !cts_s),
    .remote_halt(remote_halt), .shifter_busy(shifter_busy),
    .fifo_valid(tx_fifo_valid), .fifo_data(tx_fifo_data),
    .load(shifter_load), .data(shifter_data), .pop(tx_fifo_pop)
  );
endmodule

// File: rtl/fc_checker.sv
module fc_checker #(
  parameter int LVL_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             shifter_load,
  input logic             shifter_busy,
  input logic             cts_s,
  input logic             cts_en,
  input logic             rts_en,
  input logic             rts_n,
  input logic [LVL_W-1:0] rx_level,
  input logic [LVL_W-1:0] trig_level,
  input logic             rx_sw,
  input logic             dual,
  input logic             rx_valid,
  input logic [7:0]       rx_char,
  input logic [7:0]       off1,
  input logic             rx_store_valid,
  input logic             special_det
);
  a_r4_no_load_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    shifter_load |-> $past(!shifter_busy));

  a_r4_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    shifter_load |=> !shifter_load);

  a_r3_cts_gates_start: assert property (@(posedge clk) disable iff (!rst_n)
    (shifter_load && $past(cts_en)) |-> $past(!cts_s));

  a_r2_rts_off_above: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_en && rx_level >= trig_level) |=> rts_n);

  a_r2_rts_on_below: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_en && rx_level < trig_level - LVL_W'(1)) |=> !rts_n);

  a_r9_flag_with_store: assert property (@(posedge clk) disable iff (!rst_n)
    special_det |-> rx_store_valid);

  a_r7_pause_stripped: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_sw && !dual && $past(!dual) && $past(!dual, 2) && rx_valid && rx_char == off1)
      |=> !rx_store_valid);
endmodule

bind auto_flow_ctrl fc_checker #(.LVL_W(LVL_W)) u_fc_checker (
  .clk(clk), .rst_n(rst_n), .shifter_load(shifter_load),
  .shifter_busy(shifter_busy), .cts_s(cts_s), .cts_en(feat.cts_en),
  .rts_en(feat.rts_en), .rts_n(rts_n), .rx_level(rx_level),
  .trig_level(trig_level), .rx_sw(feat.rx_sw), .dual(feat.dual),
  .rx_valid(rx_valid), .rx_char(rx_char), .off1(off1),
  .rx_store_valid(rx_store_valid), .special_det(special_det)
);

// File: tb/auto_flow_ctrl_bench.sv
module auto_flow_ctrl_bench;
  localparam int DEPTH = 32;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_we = 1'b0;
  logic [2:0]       cfg_addr = '0;
  logic [7:0]       cfg_wdata = '0;
  logic [LVL_W-1:0] rx_level = '0;
  logic             rx_valid = 1'b0;
  logic [7:0]       rx_char = '0;
  logic             rx_store_valid;
  logic [7:0]       rx_store_data;
  logic             special_det;
  logic             tx_fifo_valid;
  logic [7:0]       tx_fifo_data;
  logic             tx_fifo_pop;
  logic             shifter_busy;
  logic             shifter_load;
  logic [7:0]       shifter_data;
  logic             cts_n = 1'b0;
  logic             rts_n;

  int n_checks = 0;
  int n_fails = 0;
  bit done = 1'b0;

  logic [7:0] tx_mem [0:255];
  int tx_wr = 0, tx_rd = 0;
  logic [7:0] tx_log [0:255];
  int tx_n = 0;
  logic [7:0] rx_log [0:255];
  int rx_n = 0;
  int spec_n = 0;
  int bit_cyc = 10;
  int busy_cnt = 0;

  always #5 clk = ~clk;

  assign tx_fifo_valid = (tx_rd != tx_wr);
  assign tx_fifo_data  = tx_mem[tx_rd[7:0]];
  assign shifter_busy  = (busy_cnt != 0);

  auto_flow_ctrl #(.DEPTH(DEPTH)) u_auto_flow_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .rx_level(rx_level), .rx_valid(rx_valid),
    .rx_char(rx_char), .rx_store_valid(rx_store_valid),
    .rx_store_data(rx_store_data), .special_det(special_det),
    .tx_fifo_valid(tx_fifo_valid), .tx_fifo_data(tx_fifo_data),
    .tx_fifo_pop(tx_fifo_pop), .shifter_busy(shifter_busy),
    .shifter_load(shifter_load), .shifter_data(shifter_data),
    .cts_n(cts_n), .rts_n(rts_n)
  );

  // Shifter, FIFO and receive-stream models, observed away from the edge
  always @(negedge clk) begin
    if (shifter_load) begin
      tx_log[tx_n[7:0]] = shifter_data;
      tx_n = tx_n + 1;
      busy_cnt = bit_cyc;
    end else if (busy_cnt > 0) begin
      busy_cnt = busy_cnt - 1;
    end
    if (tx_fifo_pop) tx_rd = tx_rd + 1;
    if (rx_store_valid) begin
      rx_log[rx_n[7:0]] = rx_store_data;
      rx_n = rx_n + 1;
    end
    if (special_det) spec_n = spec_n + 1;
  end

  function automatic int trig_of(input int sel);
    case (sel)
      0: return DEPTH / 4;
      1: return DEPTH / 2;
      2: return (3 * DEPTH) / 4;
      default: return DEPTH - 4;
    endcase
  endfunction

  function automatic bit rts_model(input bit prev, input int lvl, input int trig);
    if (lvl >= trig) return 1'b1;
    if (lvl < trig - 1) return 1'b0;
    return prev;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send_rx(input logic [7:0] c);
    @(negedge clk);
    rx_valid = 1'b1; rx_char = c;
    @(negedge clk);
    rx_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic push_tx(input logic [7:0] d);
    tx_mem[tx_wr[7:0]] = d;
    tx_wr = tx_wr + 1;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    int base;
    bit exp_rts;
    void'($urandom(32'd4242));
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);

    // R10: reset state
    check(rts_n === 1'b1, "R10 rts_n", rts_n, 1);
    check(shifter_load === 1'b0 && tx_fifo_pop === 1'b0, "R10 load/pop", shifter_load, 0);
    check(rx_store_valid === 1'b0 && special_det === 1'b0, "R10 store/flag", rx_store_valid, 0);

    // R2 with R1 trigger selection: random levels against the hysteresis model
    for (int s = 0; s < 4; s++) begin
      cfg_write(3'd1, 8'(s));
      cfg_write(3'd0, 8'h10);
      exp_rts = rts_n;
      for (int i = 0; i < 30; i++) begin
        int lvl;
        if (i < 4) lvl = trig_of(s) - 2 + i;
        else       lvl = $urandom_range(0, DEPTH);
        @(negedge clk);
        rx_level = LVL_W'(lvl);
        exp_rts = rts_model(exp_rts, lvl, trig_of(s));
        @(negedge clk);
        check(rts_n === exp_rts, "R2 R1 rts hysteresis", rts_n, exp_rts);
      end
    end
    cfg_write(3'd0, 8'h00);
    @(negedge clk);
    rx_level = '0;
    wait_cyc(2);
    check(rts_n === 1'b1, "R2 rts off when disabled", rts_n, 1);

    // R4: plain pass-through of data in order
    base = tx_n;
    for (int i = 0; i < 6; i++) push_tx(8'($urandom_range(0, 255)));
    wait_cyc(120);
    check(tx_n - base == 6, "R4 count", tx_n - base, 6);
    for (int i = 0; i < 6; i++)
      check(tx_log[(base + i) % 256] === tx_mem[(base + i) % 256], "R4 order",
            tx_log[(base + i) % 256], tx_mem[(base + i) % 256]);

    // R3: CTS gating
    cfg_write(3'd0, 8'h20);
    cts_n = 1'b1;
    wait_cyc(4);
    base = tx_n;
    push_tx(8'hA1); push_tx(8'hA2);
    wait_cyc(80);
    check(tx_n == base, "R3 no start while cts inactive", tx_n - base, 0);
    cts_n = 1'b0;
    wait_cyc(60);
    check(tx_n - base == 2 && tx_log[base % 256] === 8'hA1, "R3 resumes", tx_n - base, 2);

    // R7: single-character remote pause/resume, stripped from receive stream
    cfg_write(3'd0, 8'h02);
    base = rx_n;
    send_rx(8'h13);
    check(rx_n == base, "R7 pause stripped", rx_n - base, 0);
    send_rx(8'h41);
    check(rx_n - base == 1 && rx_log[base % 256] === 8'h41, "R7 data kept", rx_log[base % 256], 8'h41);
    base = tx_n;
    push_tx(8'hB1);
    wait_cyc(60);
    check(tx_n == base, "R7 data halted", tx_n - base, 0);
    send_rx(8'h11);
    wait_cyc(30);
    check(tx_n - base == 1 && tx_log[base % 256] === 8'hB1, "R7 resumed", tx_n - base, 1);

    // R9: special character passes and flags
    cfg_write(3'd6, 8'h7E);
    cfg_write(3'd0, 8'h0A);
    base = rx_n;
    begin
      int sb = spec_n;
      send_rx(8'h7E);
      send_rx(8'h7D);
      check(rx_n - base == 2 && rx_log[base % 256] === 8'h7E, "R9 stored", rx_log[base % 256], 8'h7E);
      check(spec_n - sb == 1, "R9 flag count", spec_n - sb, 1);
    end

    // R8: two-character mode matching and partial release
    cfg_write(3'd3, 8'h91);
    cfg_write(3'd5, 8'h93);
    cfg_write(3'd0, 8'h06);
    base = rx_n;
    send_rx(8'h13); send_rx(8'h93);
    check(rx_n == base, "R8 pair stripped", rx_n - base, 0);
    base = tx_n;
    push_tx(8'hC1);
    wait_cyc(50);
    check(tx_n == base, "R8 pair halts", tx_n - base, 0);
    send_rx(8'h11); send_rx(8'h91);
    wait_cyc(30);
    check(tx_n - base == 1, "R8 pair resumes", tx_n - base, 1);
    base = rx_n;
    send_rx(8'h13); send_rx(8'h55);
    check(rx_n - base == 2, "R8 partial count", rx_n - base, 2);
    check(rx_log[base % 256] === 8'h13, "R8 partial first", rx_log[base % 256], 8'h13);
    check(rx_log[(base + 1) % 256] === 8'h55, "R8 partial second", rx_log[(base + 1) % 256], 8'h55);
    // random data through the two-character filter
    base = rx_n;
    for (int i = 0; i < 16; i++) begin
      logic [7:0] c;
      c = 8'($urandom_range(32, 126));
      rx_mem_exp[i] = c;
      send_rx(c);
    end
    for (int i = 0; i < 16; i++)
      check(rx_log[(base + i) % 256] === rx_mem_exp[i], "R8 random data",
            rx_log[(base + i) % 256], rx_mem_exp[i]);

    // R5: single-character insertion, once per crossing
    cfg_write(3'd1, 8'h00);
    cfg_write(3'd0, 8'h01);
    base = tx_n;
    @(negedge clk); rx_level = LVL_W'(8);
    wait_cyc(40);
    check(tx_n - base == 1 && tx_log[base % 256] === 8'h13, "R5 pause sent once", tx_log[base % 256], 8'h13);
    @(negedge clk); rx_level = LVL_W'(7);
    wait_cyc(40);
    check(tx_n - base == 2 && tx_log[(base + 1) % 256] === 8'h11, "R5 resume sent", tx_log[(base + 1) % 256], 8'h11);
    // R5: two-character insertion
    cfg_write(3'd0, 8'h05);
    base = tx_n;
    @(negedge clk); rx_level = LVL_W'(20);
    wait_cyc(60);
    check(tx_n - base == 2, "R5 dual pause count", tx_n - base, 2);
    check(tx_log[base % 256] === 8'h13 && tx_log[(base + 1) % 256] === 8'h93,
          "R5 dual pause order", tx_log[(base + 1) % 256], 8'h93);
    @(negedge clk); rx_level = '0;
    wait_cyc(60);
    check(tx_log[(base + 2) % 256] === 8'h11 && tx_log[(base + 3) % 256] === 8'h91,
          "R5 dual resume order", tx_log[(base + 3) % 256], 8'h91);

    // R6: inserted pause overtakes waiting data without cutting the current frame
    cfg_write(3'd0, 8'h01);
    bit_cyc = 40;
    base = tx_n;
    push_tx(8'hD0); push_tx(8'hD1); push_tx(8'hD2);
    wait_cyc(10);
    rx_level = LVL_W'(9);
    wait_cyc(200);
    check(tx_n - base == 4, "R6 count", tx_n - base, 4);
    check(tx_log[base % 256] === 8'hD0, "R6 current frame first", tx_log[base % 256], 8'hD0);
    check(tx_log[(base + 1) % 256] === 8'h13, "R6 pause next", tx_log[(base + 1) % 256], 8'h13);
    check(tx_log[(base + 2) % 256] === 8'hD1 && tx_log[(base + 3) % 256] === 8'hD2,
          "R6 data after", tx_log[(base + 3) % 256], 8'hD2);

    // R1: reset values of the programmable characters via the line
    rst_n = 1'b0;
    wait_cyc(2);
    rst_n = 1'b1;
    bit_cyc = 10;
    cfg_write(3'd0, 8'h05);
    base = tx_n;
    wait_cyc(40);
    check(tx_n - base == 2 && tx_log[(base + 1) % 256] === 8'h00, "R1 second pause resets to 0",
          tx_log[(base + 1) % 256], 0);
    check(tx_log[base % 256] === 8'h13, "R1 first pause reset value", tx_log[base % 256], 8'h13);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  logic [7:0] rx_mem_exp [0:15];
endmodule